// File: doc/BRIEF.md
# Cartridge Program and Pattern Bank Mapper

This block sits between a CPU, a video address bus and two banked ROMs. The CPU programs it by writing bytes into a sixteen-byte register window. It then turns each CPU program address and each video pattern address into the upper address bits of the ROM behind it. All translation is combinational, so a ROM can use the outputs in the same cycle as the address that produced them.

The CPU program space from $8000 to $FFFF is split into four 8 KiB slots. Three of the slots are switchable. The top slot is always tied to the last bank of a 128 KiB program ROM. The video pattern space from $0000 to $1FFF is split into one half of two 2 KiB slots and one half of four 1 KiB slots. A control bit sets which half sits low and which sits high. The same control register sets the nametable A10 select, which gives horizontal or vertical mirroring.

A register write takes effect at the rising clock edge on which it is sampled. From then on it is visible on the outputs.

Top module: `cart_bank_mapper`

## Requirements
- R1: After a synchronous reset, every select register holds 0. So $8000, $A000 and $C000 map bank 0, every video slot maps bank 0, the halves are not swapped, and mirroring is horizontal.
- R2: Register state changes only on a write whose full 16-bit CPU address lies in $7EF0-$7EFF. Writes to any other address change no output. Writes to the unassigned window offsets $7EF7-$7EF9 and $7EFD-$7EFF also change no output.
- R3: Writing to $7EFA, $7EFB or $7EFC selects the program bank for $8000-$9FFF, $A000-$BFFF or $C000-$DFFF. The bank number is bits 5:2 of the written byte, and bits 7:6 and 1:0 are ignored. The bank appears on `prg_bank`.
- R4: For CPU addresses $E000-$FFFF, `prg_bank` is always 4'hF.
- R5: In the 2 KiB half, video A11=0 uses the select at $7EF0 and A11=1 uses the select at $7EF1. `chr_bank` is bits 7:1 of that select followed by video A10, so bit 0 of the written byte is ignored.
- R6: In the 1 KiB half, video A11:A10 = 0, 1, 2 or 3 selects the full 8-bit value written to $7EF2, $7EF3, $7EF4 or $7EF5, and that value is driven on `chr_bank`.
- R7: With bit 1 of $7EF6 at 0, the 2 KiB half is at video A12=0 and the 1 KiB half is at A12=1. With bit 1 at 1, the two halves swap places.
- R8: Bit 0 of $7EF6 sets mirroring. At 0 (horizontal), `ntbl_a10` follows video A11. At 1 (vertical), it follows video A10.
- R9: For CPU addresses below $8000, `prg_bank` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, sampled at the rising edge |
| vid_addr_hi | input | 3 | Video address bits 12:10 |
| prg_bank | output | 4 | Program ROM address bits 16:13 |
| chr_bank | output | 8 | Pattern ROM address bits 17:10 |
| ntbl_a10 | output | 1 | Nametable A10 select |

## Verification
In one cycle, a CPU register write can change a select while the same CPU address and the video address are being translated. The bench provokes this in two ways. It writes to addresses just outside the window and to the unassigned window offsets, and then probes every slot, expecting the earlier mapping to be unchanged. It also rewrites the control register and probes the same video addresses in each of the four swap and mirroring combinations. Every probe is judged against values worked out by hand from the written bytes.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

    localparam int PRG_BANK_W = 4;
    localparam int CHR_BANK_W = 8;
    localparam int CHR2K_W    = CHR_BANK_W - 1;
    localparam int NUM_PRG    = 3;
    localparam int NUM_CHR2K  = 2;
    localparam int NUM_CHR1K  = 4;
    localparam logic [15:0] WIN_BASE = 16'h7EF0;
    localparam logic [PRG_BANK_W-1:0] PRG_LAST = '1;

    typedef enum logic [3:0] {
        IDX_CHR2K0 = 4'h0,
        IDX_CHR2K1 = 4'h1,
        IDX_CHR1K0 = 4'h2,
        IDX_CHR1K1 = 4'h3,
        IDX_CHR1K2 = 4'h4,
        IDX_CHR1K3 = 4'h5,
        IDX_MODE   = 4'h6,
        IDX_PRG0   = 4'hA,
        IDX_PRG1   = 4'hB,
        IDX_PRG2   = 4'hC
    } reg_idx_e;

    typedef struct packed {
        logic [NUM_PRG-1:0][PRG_BANK_W-1:0]   prg;
        logic [NUM_CHR2K-1:0][CHR2K_W-1:0]    chr2k;
        logic [NUM_CHR1K-1:0][CHR_BANK_W-1:0] chr1k;
        logic                                 chr_swap;
        logic                                 mirror_v;
    } map_regs_t;

    function automatic logic window_hit(input logic [15:0] a);
        return a[15:4] == WIN_BASE[15:4];
    endfunction

    function automatic logic [PRG_BANK_W-1:0] prg_field(input logic [7:0] d);
        return d[5:2];
    endfunction

endpackage

// File: rtl/cart_map_regs.sv
module cart_map_regs
    import cart_map_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_data,
    input  logic        cpu_wr,
    output map_regs_t   regs
);

    logic     wr_hit;
    reg_idx_e idx;

    assign wr_hit = cpu_wr && window_hit(cpu_addr);
    assign idx    = reg_idx_e'(cpu_addr[3:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (wr_hit) begin
            case (idx)
                IDX_CHR2K0: regs.chr2k[0] <= cpu_data[7:1];
                IDX_CHR2K1: regs.chr2k[1] <= cpu_data[7:1];
                IDX_CHR1K0: regs.chr1k[0] <= cpu_data;
                IDX_CHR1K1: regs.chr1k[1] <= cpu_data;
                IDX_CHR1K2: regs.chr1k[2] <= cpu_data;
                IDX_CHR1K3: regs.chr1k[3] <= cpu_data;
                IDX_MODE: begin
                    regs.chr_swap <= cpu_data[1];
                    regs.mirror_v <= cpu_data[0];
                end
                IDX_PRG0:   regs.prg[0] <= prg_field(cpu_data);
                IDX_PRG1:   regs.prg[1] <= prg_field(cpu_data);
                IDX_PRG2:   regs.prg[2] <= prg_field(cpu_data);
                default: ;
            endcase
        end
    end

    // R2: no write inside the window means no change of state
    p_ignore_outside_r2: assert property (@(posedge clk) disable iff (rst)
        !(cpu_wr && cpu_addr[15:4] == 12'h7EF) |=> $stable(regs));

    // R3: the first program slot takes bits 5:2 of the byte written to offset A
    p_prg_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == 16'h7EFA) |=> (regs.prg[0] == $past(cpu_data[5:2])));

endmodule

// File: rtl/cart_prg_map.sv
module cart_prg_map
    import cart_map_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2:0]            cpu_slot,
    input  map_regs_t             regs,
    output logic [PRG_BANK_W-1:0] prg_bank
);

    always_comb begin
        case (cpu_slot)
            3'b100:  prg_bank = regs.prg[0];
            3'b101:  prg_bank = regs.prg[1];
            3'b110:  prg_bank = regs.prg[2];
            3'b111:  prg_bank = PRG_LAST;
            default: prg_bank = '0;
        endcase
    end

    // R4: the top slot never moves
    p_fixed_last_r4: assert property (@(posedge clk) disable iff (rst)
        (cpu_slot == 3'b111) |-> (prg_bank == 4'hF));

    // R9: below $8000 the bank output is 0
    p_low_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !cpu_slot[2] |-> (prg_bank == 4'h0));

endmodule

// File: rtl/cart_chr_map.sv
module cart_chr_map
    import cart_map_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2:0]            vid_addr_hi,
    input  map_regs_t             regs,
    output logic [CHR_BANK_W-1:0] chr_bank,
    output logic                  ntbl_a10
);

    logic                          in_1k_half;
    logic [CHR2K_W-1:0]            sel2k;
    logic [CHR_BANK_W-1:0]         sel1k;
    logic [NUM_CHR1K-1:0]          slot1k_hot;

    assign in_1k_half = vid_addr_hi[2] ^ regs.chr_swap;
    assign sel2k      = vid_addr_hi[1] ? regs.chr2k[1] : regs.chr2k[0];

    for (genvar g = 0; g < NUM_CHR1K; g++) begin : g_slot1k
        assign slot1k_hot[g] = (vid_addr_hi[1:0] == g[1:0]);
    end

    always_comb begin
        sel1k = '0;
        for (int i = 0; i < NUM_CHR1K; i++) begin
            if (slot1k_hot[i]) sel1k = regs.chr1k[i];
        end
    end

    assign chr_bank = in_1k_half ? sel1k : {sel2k, vid_addr_hi[0]};
    assign ntbl_a10 = regs.mirror_v ? vid_addr_hi[0] : vid_addr_hi[1];

    // R5: a 2 KiB slot passes video A10 into the low bank bit
    p_2k_low_bit_r5: assert property (@(posedge clk) disable iff (rst)
        (vid_addr_hi[2] == regs.chr_swap) |-> (chr_bank[0] == vid_addr_hi[0]));

    // R6: exactly one 1 KiB slot is decoded
    p_1k_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $countones(slot1k_hot) == 1);

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import cart_map_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_data,
    input  logic        cpu_wr,
    input  logic [2:0]  vid_addr_hi,
    output logic [3:0]  prg_bank,
    output logic [7:0]  chr_bank,
    output logic        ntbl_a10
);

    map_regs_t regs;

    cart_map_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .cpu_wr   (cpu_wr),
        .regs     (regs)
    );

    cart_prg_map u_prg (
        .clk      (clk),
        .rst      (rst),
        .cpu_slot (cpu_addr[15:13]),
        .regs     (regs),
        .prg_bank (prg_bank)
    );

    cart_chr_map u_chr (
        .clk         (clk),
        .rst         (rst),
        .vid_addr_hi (vid_addr_hi),
        .regs        (regs),
        .chr_bank    (chr_bank),
        .ntbl_a10    (ntbl_a10)
    );

    // R8: once vertical mirroring is written, A10 follows video A10
    p_mirror_vertical_r8: assert property (@(posedge clk) disable iff (rst)
        $past(cpu_wr && cpu_addr == 16'h7EF6 && cpu_data[0])
        |-> (ntbl_a10 == vid_addr_hi[0]));

endmodule

// File: tb/cart_bank_mapper_bench.sv
module cart_bank_mapper_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_wr = 1'b0;
    logic [12:0] vid = 13'h0000;
    logic [3:0]  prg_bank;
    logic [7:0]  chr_bank;
    logic        ntbl_a10;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cart_bank_mapper u_cart_bank_mapper (
        .clk         (clk),
        .rst         (rst),
        .cpu_addr    (cpu_addr),
        .cpu_data    (cpu_data),
        .cpu_wr      (cpu_wr),
        .vid_addr_hi (vid[12:10]),
        .prg_bank    (prg_bank),
        .chr_bank    (chr_bank),
        .ntbl_a10    (ntbl_a10)
    );

    // fields: cpu probe, video probe, expected prg, chr, a10 (horizontal, unswapped)
    localparam int NV = 12;
    localparam logic [41:0] VEC [NV] = '{
        {16'h8000, 13'h0000, 4'h5, 8'h34, 1'b0},  // R3 R5
        {16'h9FFF, 13'h03FF, 4'h5, 8'h34, 1'b0},  // R3 R5
        {16'hA000, 13'h0400, 4'hA, 8'h35, 1'b0},  // R3 R5
        {16'hBFFF, 13'h0800, 4'hA, 8'h80, 1'b1},  // R3 R5 R8
        {16'hC000, 13'h0C00, 4'h3, 8'h81, 1'b1},  // R3 R5
        {16'hDFFF, 13'h0BFF, 4'h3, 8'h80, 1'b1},  // R3 R5
        {16'hE000, 13'h1000, 4'hF, 8'h11, 1'b0},  // R4 R6
        {16'hFFFF, 13'h1400, 4'hF, 8'h22, 1'b0},  // R4 R6
        {16'hF000, 13'h1800, 4'hF, 8'h33, 1'b1},  // R4 R6
        {16'h6000, 13'h1C00, 4'h0, 8'hFE, 1'b1},  // R9 R6
        {16'h7EFA, 13'h1FFF, 4'h0, 8'hFE, 1'b1},  // R9 R6
        {16'h0000, 13'h17FF, 4'h0, 8'h22, 1'b0}   // R9 R6
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        cpu_data = d;
        cpu_wr   = 1'b1;
        @(negedge clk);
        cpu_wr   = 1'b0;
    endtask

    task automatic probe(input logic [15:0] a, input logic [12:0] v);
        @(negedge clk);
        cpu_addr = a;
        vid      = v;
        #1;
    endtask

    task automatic load_main();
        wr(16'h7EFA, 8'hD5);
        wr(16'h7EFB, 8'h2B);
        wr(16'h7EFC, 8'h0C);
        wr(16'h7EF0, 8'h35);
        wr(16'h7EF1, 8'h80);
        wr(16'h7EF2, 8'h11);
        wr(16'h7EF3, 8'h22);
        wr(16'h7EF4, 8'h33);
        wr(16'h7EF5, 8'hFE);
        wr(16'h7EF6, 8'h00);
    endtask

    task automatic check_cleared(input string req);
        probe(16'h8000, 13'h0000); check(req, {4'h0, prg_bank}, 8'h00);
        probe(16'hA000, 13'h1400); check(req, {4'h0, prg_bank}, 8'h00);
                                   check(req, chr_bank, 8'h00);
        probe(16'hC000, 13'h0C00); check(req, {4'h0, prg_bank}, 8'h00);
                                   check(req, chr_bank, 8'h01);
        probe(16'hE000, 13'h0800); check(req, {4'h0, prg_bank}, 8'h0F);
                                   check(req, {7'h0, ntbl_a10}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check_cleared("R1");

        load_main();
        for (int i = 0; i < NV; i++) begin
            probe(VEC[i][41:26], VEC[i][25:13]);
            check("R3/R4/R9 prg", {4'h0, prg_bank}, {4'h0, VEC[i][12:9]});
            check("R5/R6 chr", chr_bank, VEC[i][8:1]);
            check("R8 a10", {7'h0, ntbl_a10}, {7'h0, VEC[i][0]});
        end

        // R7: swapped halves
        wr(16'h7EF6, 8'h02);
        probe(16'h8000, 13'h0000); check("R7", chr_bank, 8'h11);
        probe(16'h8000, 13'h0C00); check("R7", chr_bank, 8'hFE);
        probe(16'h8000, 13'h1000); check("R7", chr_bank, 8'h34);
        probe(16'h8000, 13'h1400); check("R7", chr_bank, 8'h35);
        probe(16'h8000, 13'h1800); check("R7", chr_bank, 8'h80);
                                   check("R8", {7'h0, ntbl_a10}, 8'h01);

        // R8: vertical mirroring, unswapped then swapped
        wr(16'h7EF6, 8'h01);
        probe(16'h8000, 13'h0400); check("R8", {7'h0, ntbl_a10}, 8'h01);
                                   check("R7", chr_bank, 8'h35);
        probe(16'h8000, 13'h0800); check("R8", {7'h0, ntbl_a10}, 8'h00);
        wr(16'h7EF6, 8'h03);
        probe(16'h8000, 13'h0400); check("R8", {7'h0, ntbl_a10}, 8'h01);
                                   check("R7", chr_bank, 8'h22);
        probe(16'h8000, 13'h1800); check("R8", {7'h0, ntbl_a10}, 8'h00);
                                   check("R7", chr_bank, 8'h80);

        // R2: writes outside the window and to unassigned offsets
        wr(16'h7EF6, 8'hFC);
        wr(16'h6EFA, 8'h3C);
        wr(16'hFEFA, 8'h3C);
        wr(16'h7EEA, 8'h3C);
        wr(16'h7FF0, 8'hFF);
        wr(16'h7EE6, 8'h03);
        wr(16'h7EF7, 8'hFF);
        wr(16'h7EF8, 8'hFF);
        wr(16'h7EF9, 8'hFF);
        wr(16'h7EFD, 8'hFF);
        wr(16'h7EFE, 8'hFF);
        wr(16'h7EFF, 8'hFF);
        probe(16'h8000, 13'h0000); check("R2", {4'h0, prg_bank}, 8'h05);
                                   check("R2", chr_bank, 8'h34);
        probe(16'hA000, 13'h0800); check("R2", {4'h0, prg_bank}, 8'h0A);
                                   check("R2", {7'h0, ntbl_a10}, 8'h01);
        probe(16'hC000, 13'h1C00); check("R2", {4'h0, prg_bank}, 8'h03);
                                   check("R2", chr_bank, 8'hFE);

        // R3: ignored bits only, and full-range value
        wr(16'h7EFA, 8'hC3);
        probe(16'h8000, 13'h0000); check("R3", {4'h0, prg_bank}, 8'h00);
        wr(16'h7EFB, 8'h3C);
        probe(16'hA000, 13'h0000); check("R3", {4'h0, prg_bank}, 8'h0F);
        // R5: bit 0 of a 2 KiB select is dropped
        wr(16'h7EF1, 8'hFF);
        probe(16'h8000, 13'h0800); check("R5", chr_bank, 8'hFE);
        probe(16'h8000, 13'h0C00); check("R5", chr_bank, 8'hFF);

        // R1: reset in mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_cleared("R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule